// File: doc/BRIEF.md
# Video Clamp Pulse Generator

This block produces one active-low clamp pulse per video line, timed against a horizontal sync that arrives already normalized to active-low and synchronized to the block clock. A signed control value picks where the pulse lands. Values at or below zero place it on the back porch, a fixed short delay after sync ends. Values of two and above place it on the sync tip, a short delay after sync begins. The magnitude of the control value sets how narrow the pulse is.

The sync-tip delay is a fixed fraction of the line period, about 2.5 %. That period is taken from the interval between the two most recent sync leading edges. When the sync-present flag is low, the block runs a free-running line timer whose period is set by an input. In sync-tip mode it keeps clamping from that timer, so an on-screen display still gets clamped with no video source attached. In back-porch mode with no sync, it stays silent.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While rst_ni is low and after it is released with no sync activity, clamp_no is high and the placement mode is back-porch.
- R2: Mode selection uses one code of hysteresis. A control value of 2 or more selects sync-tip mode from the next clock. A value of 0 or less selects back-porch mode from the next clock. A value of exactly 1 keeps the current mode.
- R3: Pulse width in clock cycles is 128 - ((|ctrl| * 120) >> 7), where |ctrl| is the magnitude of the 8-bit two's-complement control value. This gives 128 cycles at 0 and 8 cycles at -128.
- R4: In back-porch mode with sync present, clamp_no falls 11 rising edges after the edge that first samples hsync_ni high after a low phase (the trailing edge). The delay is BP_DELAY = 10 plus one.
- R5: In sync-tip mode with sync present, clamp_no falls D+1 rising edges after the edge that first samples hsync_ni low. D = (P * 13) >> 9, and P is the cycle count between the two preceding leading edges.
- R6: Exactly one pulse occurs per line. Leading edges are ignored in back-porch mode and trailing edges are ignored in sync-tip mode.
- R7: In sync-tip mode with sync_present_i low, pulses repeat every free_period_i cycles. The delay is D = (free_period_i * 13) >> 9, and hsync_ni is ignored.
- R8: In back-porch mode with sync_present_i low, clamp_no stays high whatever hsync_ni does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_ni | input | 1 | Normalized horizontal sync, active low, synchronous to clk_i |
| sync_present_i | input | 1 | High when a sync source is detected |
| ctrl_i | input | 8 | Signed placement and width control |
| free_period_i | input | 16 | Free-running line period in clock cycles |
| clamp_no | output | 1 | Clamp pulse, active low |

## Verification
The hardest state to reach is the sync-tip delay, because it depends on a period measured across earlier lines. The first leading edge after reset or after a long idle stretch carries a stale, saturated count. That can push the pulse past the next line start and cause a leading edge to be skipped. The stimulus therefore runs several back-to-back warm-up lines of a fixed length before it measures. It accounts for the extra cycles that each control change inserts between lines.

The hysteresis case is reached by approaching the control code 1 once from sync-tip mode and once from back-porch mode. Each time, a full line is run to show which placement the pulse keeps.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  typedef enum logic {
    MODE_PORCH = 1'b0,
    MODE_TIP   = 1'b1
  } clamp_mode_e;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_DELAY = 2'd1,
    SH_PULSE = 2'd2
  } shaper_state_e;
endpackage

// File: rtl/clamp_mode_sel.sv
module clamp_mode_sel
  import clamp_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int W_MIN  = 8,
  parameter int W_MAX  = 128,
  parameter int WID_W  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [CTRL_W-1:0] ctrl_i,
  output clamp_mode_e              mode_o,
  output logic [WID_W-1:0]         width_o
);
  localparam int SPAN   = W_MAX - W_MIN;
  localparam int PROD_W = CTRL_W + $clog2(SPAN + 1);
  localparam logic signed [CTRL_W-1:0] ONE = 1;
  localparam logic signed [CTRL_W-1:0] ZERO = 0;

  logic [CTRL_W-1:0] mag;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] shrink;

  // magnitude of most negative code still fits unsigned
  assign mag     = ctrl_i[CTRL_W-1] ? CTRL_W'(-ctrl_i) : CTRL_W'(ctrl_i);
  assign prod    = PROD_W'(mag) * PROD_W'(SPAN);
  assign shrink  = prod >> (CTRL_W - 1);
  assign width_o = WID_W'(W_MAX) - WID_W'(shrink);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_PORCH;
    end else if (ctrl_i > ONE) begin
      mode_o <= MODE_TIP;
    end else if (ctrl_i <= ZERO) begin
      mode_o <= MODE_PORCH;
    end
  end
endmodule

// File: rtl/clamp_line_timer.sv
module clamp_line_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_ni,
  input  logic             sync_present_i,
  input  logic [PER_W-1:0] free_period_i,
  output logic             lead_o,
  output logic             trail_o,
  output logic             fr_tick_o,
  output logic [PER_W-1:0] period_o
);
  logic             hs_q;
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] period_q;
  logic [PER_W-1:0] fr_cnt_q;

  assign lead_o    = sync_present_i & hs_q & ~hsync_ni;
  assign trail_o   = sync_present_i & ~hs_q & hsync_ni;
  assign fr_tick_o = ~sync_present_i &
                     ((PER_W+1)'(fr_cnt_q) + (PER_W+1)'(1) >= (PER_W+1)'(free_period_i));
  assign period_o  = sync_present_i ? period_q : free_period_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q     <= 1'b1;
      cnt_q    <= '0;
      period_q <= '0;
      fr_cnt_q <= '0;
    end else begin
      hs_q <= hsync_ni;
      if (lead_o) begin
        period_q <= cnt_q + PER_W'(1);
        cnt_q    <= '0;
      end else if (cnt_q != '1) begin
        cnt_q <= cnt_q + PER_W'(1);
      end
      if (sync_present_i || fr_tick_o) fr_cnt_q <= '0;
      else                             fr_cnt_q <= fr_cnt_q + PER_W'(1);
    end
  end
endmodule

// File: rtl/clamp_shaper.sv
module clamp_shaper
  import clamp_pkg::*;
#(
  parameter int PER_W = 16,
  parameter int WID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PER_W-1:0] delay_i,
  input  logic [WID_W-1:0] width_i,
  output logic             active_o
);
  shaper_state_e    state_q;
  logic [PER_W-1:0] dcnt_q;
  logic [WID_W-1:0] wcnt_q;
  logic [WID_W-1:0] w_q;

  assign active_o = (state_q == SH_PULSE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SH_IDLE;
      dcnt_q  <= '0;
      wcnt_q  <= '0;
      w_q     <= '0;
    end else begin
      unique case (state_q)
        SH_IDLE: if (start_i) begin
          state_q <= SH_DELAY;
          dcnt_q  <= delay_i;
          w_q     <= width_i;
        end
        SH_DELAY: if (dcnt_q == '0) begin
          state_q <= SH_PULSE;
          wcnt_q  <= w_q - WID_W'(1);
        end else begin
          dcnt_q <= dcnt_q - PER_W'(1);
        end
        SH_PULSE: if (wcnt_q == '0) state_q <= SH_IDLE;
                  else              wcnt_q  <= wcnt_q - WID_W'(1);
        default: state_q <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
  import clamp_pkg::*;
#(
  parameter int CTRL_W   = 8,
  parameter int PER_W    = 16,
  parameter int W_MIN    = 8,
  parameter int W_MAX    = 128,
  parameter int BP_DELAY = 10,
  parameter int TIP_MUL  = 13,
  parameter int TIP_SHR  = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     hsync_ni,
  input  logic                     sync_present_i,
  input  logic signed [CTRL_W-1:0] ctrl_i,
  input  logic [PER_W-1:0]         free_period_i,
  output logic                     clamp_no
);
  localparam int WID_W = $clog2(W_MAX + 1);
  localparam int SCL_W = PER_W + $clog2(TIP_MUL + 1);

  clamp_mode_e      mode;
  logic [WID_W-1:0] width;
  logic             lead, trail, fr_tick, start, active;
  logic [PER_W-1:0] period, tip_delay, delay;
  logic [SCL_W-1:0] scaled;

  clamp_mode_sel #(
    .CTRL_W(CTRL_W), .W_MIN(W_MIN), .W_MAX(W_MAX), .WID_W(WID_W)
  ) u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl_i),
    .mode_o(mode), .width_o(width)
  );

  clamp_line_timer #(.PER_W(PER_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsync_ni(hsync_ni),
    .sync_present_i(sync_present_i), .free_period_i(free_period_i),
    .lead_o(lead), .trail_o(trail), .fr_tick_o(fr_tick), .period_o(period)
  );

  // ~2.5% of line period without a divider
  assign scaled    = SCL_W'(period) * SCL_W'(TIP_MUL);
  assign tip_delay = PER_W'(scaled >> TIP_SHR);
  assign start     = (mode == MODE_TIP) ? (lead | fr_tick) : trail;
  assign delay     = (mode == MODE_TIP) ? tip_delay : PER_W'(BP_DELAY);

  clamp_shaper #(.PER_W(PER_W), .WID_W(WID_W)) u_shaper (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .delay_i(delay), .width_i(width), .active_o(active)
  );

  assign clamp_no = ~active;
endmodule

// File: rtl/clamp_pulse_gen_chk.sv
module clamp_pulse_gen_chk
  import clamp_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int W_MIN  = 8,
  parameter int W_MAX  = 128
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic signed [CTRL_W-1:0] ctrl_i,
  input logic                     clamp_no,
  input clamp_mode_e              mode_i
);
  localparam logic signed [CTRL_W-1:0] ONE = 1;
  localparam logic signed [CTRL_W-1:0] ZERO = 0;
  logic [15:0] low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       low_run <= '0;
    else if (!clamp_no) low_run <= low_run + 16'd1;
    else               low_run <= '0;
  end

  assert_width_bounds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clamp_no) |-> (low_run >= 16'(W_MIN) && low_run <= 16'(W_MAX)));

  assert_enter_tip_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i > ONE) |=> (mode_i == MODE_TIP));

  assert_enter_porch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i <= ZERO) |=> (mode_i == MODE_PORCH));

  assert_hold_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i == ONE) |=> $stable(mode_i));
endmodule

bind clamp_pulse_gen clamp_pulse_gen_chk #(
  .CTRL_W(CTRL_W), .W_MIN(W_MIN), .W_MAX(W_MAX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl_i),
  .clamp_no(clamp_no), .mode_i(mode)
);

// File: tb/tb_clamp_pulse_gen.sv
module tb_clamp_pulse_gen;
  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              hsync_ni = 1'b1;
  logic              sync_present_i = 1'b1;
  logic signed [7:0] ctrl_i = 8'sd0;
  logic [15:0]       free_period_i = 16'd400;
  logic              clamp_no;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  clamp_pulse_gen dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_w(input int c);
    int m = (c < 0) ? -c : c;
    return 128 - ((m * 120) >> 7);
  endfunction

  function automatic int exp_d(input int p);
    return (p * 13) >> 9;
  endfunction

  task automatic set_ctrl(input int v);
    ctrl_i = 8'(v);
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // one line: sync low for l cycles, total t cycles; index 0 = edge sampling lead
  task automatic run_line(input int l, input int t, output int first, output int wid, output int falls);
    logic prev;
    first = -1; wid = 0; falls = 0;
    prev = clamp_no;
    hsync_ni = 1'b0;
    for (int i = 0; i < t; i++) begin
      @(posedge clk_i); #1;
      if (!clamp_no) begin
        if (first < 0) first = i;
        wid++;
      end
      if (prev && !clamp_no) falls++;
      prev = clamp_no;
      @(negedge clk_i);
      if (i == l - 1) hsync_ni = 1'b1;
    end
  endtask

  task automatic t_reset();
    #1;
    check(clamp_no === 1'b1, "R1 clamp high in reset", int'(clamp_no), 1);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (20) @(negedge clk_i);
    check(clamp_no === 1'b1, "R1 clamp high after reset", int'(clamp_no), 1);
  endtask

  task automatic t_porch();
    int f, w, n;
    set_ctrl(-64);
    run_line(80, 800, f, w, n);
    run_line(80, 800, f, w, n);
    check(f == 91, "R4 porch delay", f, 91);
    check(w == exp_w(-64), "R3 width -64", w, exp_w(-64));
    check(n == 1, "R6 porch one pulse per line", n, 1);
  endtask

  task automatic t_zero_and_min();
    int f, w, n;
    set_ctrl(0);
    run_line(80, 800, f, w, n);
    check(f == 91, "R2 zero selects porch", f, 91);
    check(w == 128, "R3 width at zero", w, 128);
    set_ctrl(-128);
    run_line(80, 800, f, w, n);
    check(w == 8, "R3 width at -128", w, 8);
    check(f == 91, "R4 porch delay at -128", f, 91);
  endtask

  task automatic t_tip(input int c, input int t);
    int f, w, n;
    set_ctrl(c);
    repeat (4) run_line(80, t, f, w, n);
    run_line(80, t, f, w, n);
    check(f == exp_d(t) + 1, "R5 tip delay", f, exp_d(t) + 1);
    check(w == exp_w(c), "R3 tip width", w, exp_w(c));
    check(n == 1, "R6 tip one pulse per line", n, 1);
  endtask

  task automatic t_hyst();
    int f, w, n;
    set_ctrl(1);
    run_line(80, 1200, f, w, n);
    check(f == exp_d(1202) + 1, "R2 code 1 keeps tip", f, exp_d(1202) + 1);
    check(w == exp_w(1), "R3 width at 1", w, exp_w(1));
    set_ctrl(0);
    set_ctrl(1);
    run_line(80, 1200, f, w, n);
    check(f == 91, "R2 code 1 keeps porch", f, 91);
    check(n == 1, "R6 porch line single pulse", n, 1);
    set_ctrl(2);
    run_line(80, 1200, f, w, n);
    check(f == exp_d(1202) + 1, "R2 code 2 enters tip", f, exp_d(1202) + 1);
    check(w == exp_w(2), "R3 width at 2", w, exp_w(2));
  endtask

  task automatic t_free();
    int fall_t[8];
    int nf = 0, run = 0, last_w = 0;
    logic prev;
    sync_present_i = 1'b0;
    free_period_i = 16'd400;
    set_ctrl(100);
    prev = clamp_no;
    for (int i = 0; i < 1400; i++) begin
      @(posedge clk_i); #1;
      if (prev && !clamp_no && nf < 8) begin fall_t[nf] = i; nf++; end
      if (!clamp_no) run++;
      else if (!prev) begin last_w = run; run = 0; end
      prev = clamp_no;
      @(negedge clk_i);
      if (i == 500) hsync_ni = 1'b0;
      if (i == 560) hsync_ni = 1'b1;
    end
    check(nf >= 3, "R7 free-run pulses present", nf, 3);
    if (nf >= 3) begin
      check(fall_t[1] - fall_t[0] == 400, "R7 free-run interval", fall_t[1] - fall_t[0], 400);
      check(fall_t[2] - fall_t[1] == 400, "R7 interval with hsync ignored", fall_t[2] - fall_t[1], 400);
    end
    check(last_w == exp_w(100), "R3 free-run width", last_w, exp_w(100));
  endtask

  task automatic t_porch_nosync();
    int f, w, n, tot = 0;
    set_ctrl(-10);
    repeat (300) @(negedge clk_i);
    for (int k = 0; k < 3; k++) begin
      run_line(80, 800, f, w, n);
      tot += w;
    end
    check(tot == 0, "R8 porch without sync silent", tot, 0);
  endtask

  initial begin
    t_reset();
    t_porch();
    t_zero_and_min();
    t_tip(127, 800);
    t_tip(32, 1200);
    t_hyst();
    t_free();
    t_porch_nosync();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule